// File: doc/BRIEF.md
# Sync Header Separating Page Packer

This block sits between a block-aligned receive path and a 128-bit DMA write bus. It takes a continuous stream of 66-bit line-code blocks, each a 2-bit sync header with a 64-bit payload, and lays them out in fixed-size memory pages. Payloads are packed two to a 128-bit beat in the payload region of a page. Headers are packed sixteen to a 32-bit word, four words to a beat, in a header region at the start of the same page. The bus therefore carries no padding.

Every page holds a fixed number of blocks, chosen so that the header region and the payload region fill the page exactly. With the default 4096-byte page this is 496 blocks: 128 header bytes followed by 3968 payload bytes. When the last block of a page has been written, the block pulses a page-done strobe with the page index and moves on to the next page of a ring of `NUM_PAGES`. Input is held off while the ring reports that no page is free. Input is also held off for the one cycle in which a header beat takes the write port.

Top module: `shp_page_packer`

## Requirements
- R1: While reset is asserted and just after it is released, `wr_valid` and `page_done` are low and `in_ready` equals `page_free`.
- R2: The payload of block i of a page goes to byte offset HDR + 16*(i/2). Even i goes to data bits [63:0] and odd i to bits [127:64]. The write appears on the cycle after odd block i is accepted, with all 16 byte enables set. HDR is the header region size (128 by default).
- R3: The header of block i (input bits [65:64]) goes to bits [32*((i mod 64)/16) + 2*(i mod 16) +: 2] of the header beat at byte offset 16*(i/64).
- R4: After block 64k+63 or the last block of a page is accepted, its header beat is written on the cycle after the payload write. During the cycle in which that payload write is visible, `in_ready` is low.
- R5: A page takes exactly N blocks (496 for 4096-byte pages) and receives 256 beat writes. Each write address is page_index*PAGE_BYTES + offset, with the page index in the upper address bits.
- R6: The final header beat of a page is written at offset 112 with byte enables 16'h0FFF, since only 48 headers are left. `page_done` pulses for one cycle together with that write, and the payload write comes in the cycle before.
- R7: `page_done_idx` reports the page just completed. The page index counts 0 to NUM_PAGES-1 and then wraps to 0.
- R8: While `page_free` is low, `in_ready` is low and a block offered on `in_block` is not consumed.
- R9: Idle cycles on `in_valid` and stalls do not change the layout. Only accepted blocks advance the block position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block accepted when high with in_valid |
| in_block | input | 66 | [65:64] sync header, [63:0] payload |
| page_free | input | 1 | Ring has a page available to fill |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | 16 | Byte address: page index, page offset |
| wr_data | output | 128 | Write data |
| wr_be | output | 16 | Byte enables |
| page_done | output | 1 | One-cycle pulse, page complete |
| page_done_idx | output | 4 | Index of completed page |

## Verification
The first page is streamed at full rate, with a block on every cycle. This shows that the header-beat stall alone paces the input and that no block is lost or repeated around it. Later pages use random gaps in `in_valid` and random `page_free` drops. A long directed hold of `page_free` is placed mid-page with valid held high. Together these separate a design that advances on offered blocks from one that advances only on accepted blocks. Every payload and header beat is compared at its write against values rebuilt from the recorded accepted blocks. The run covers twenty pages, so the page index wraps and the partial final header beat is checked on every page.

// File: rtl/shp_pkg.sv
`timescale 1ns/1ps
package shp_pkg;
    localparam int BEAT_BITS    = 128;
    localparam int BEAT_BYTES   = 16;
    localparam int PAY_BITS     = 64;
    localparam int HDR_BITS     = 2;
    localparam int HBEAT_BLOCKS = 64;
    localparam int WORD_BLOCKS  = 16;

    // Largest even block count whose header region (rounded to beats)
    // plus payload region fits in one page.
    function automatic int blocks_per_page(input int page_bytes);
        int best;
        best = 0;
        for (int n = 2; n <= page_bytes / 8; n += 2) begin
            if (((n + HBEAT_BLOCKS - 1) / HBEAT_BLOCKS) * BEAT_BYTES + n * 8 <= page_bytes)
                best = n;
        end
        return best;
    endfunction

    function automatic int hdr_region_bytes(input int nblk);
        return ((nblk + HBEAT_BLOCKS - 1) / HBEAT_BLOCKS) * BEAT_BYTES;
    endfunction

    // Byte enables for the last header beat of a page.
    function automatic logic [BEAT_BYTES-1:0] last_hdr_be(input int nblk);
        int tail;
        int words;
        logic [BEAT_BYTES-1:0] be;
        tail  = ((nblk - 1) % HBEAT_BLOCKS) + 1;
        words = (tail + WORD_BLOCKS - 1) / WORD_BLOCKS;
        be    = '0;
        for (int w = 0; w < 4; w++)
            if (w < words) be[4*w +: 4] = 4'hF;
        return be;
    endfunction
endpackage

// File: rtl/shp_hdr_acc.sv
`timescale 1ns/1ps
module shp_hdr_acc
    import shp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 clear,
    input  logic [5:0]           pos,
    input  logic [HDR_BITS-1:0]  hdr,
    output logic [BEAT_BITS-1:0] beat
);
    logic [BEAT_BITS-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) acc_d = '0;
        if (load)  acc_d[2*int'(pos) +: HDR_BITS] = hdr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign beat = acc_q;

    // R4: the flush cycle never collides with a new header
    a_r4_no_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !load);
endmodule

// File: rtl/shp_pair_buf.sv
`timescale 1ns/1ps
module shp_pair_buf
    import shp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PAY_BITS-1:0] din,
    output logic [PAY_BITS-1:0] dout
);
    logic [PAY_BITS-1:0] lo_d, lo_q;

    always_comb begin
        lo_d = lo_q;
        if (load) lo_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lo_q <= '0;
        else        lo_q <= lo_d;
    end

    assign dout = lo_q;
endmodule

// File: rtl/shp_page_packer.sv
`timescale 1ns/1ps
module shp_page_packer
    import shp_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_PAGES  = 16
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           in_valid,
    output logic                                           in_ready,
    input  logic [65:0]                                    in_block,
    input  logic                                           page_free,
    output logic                                           wr_valid,
    output logic [$clog2(NUM_PAGES)+$clog2(PAGE_BYTES)-1:0] wr_addr,
    output logic [127:0]                                   wr_data,
    output logic [15:0]                                    wr_be,
    output logic                                           page_done,
    output logic [$clog2(NUM_PAGES)-1:0]                   page_done_idx
);
    localparam int BLK_N   = blocks_per_page(PAGE_BYTES);
    localparam int HDR_B   = hdr_region_bytes(BLK_N);
    localparam logic [BEAT_BYTES-1:0] LAST_BE = last_hdr_be(BLK_N);
    localparam int OFF_W   = $clog2(PAGE_BYTES);
    localparam int PG_W    = $clog2(NUM_PAGES);
    localparam int ADDR_W  = PG_W + OFF_W;
    localparam int BLK_W   = $clog2(BLK_N);

    typedef struct packed {
        logic [BLK_W-1:0]      blk;
        logic [PG_W-1:0]       page;
        logic                  pend;
        logic                  pend_last;
        logic [BLK_W-1:0]      hbeat;
        logic                  wr_valid;
        logic [ADDR_W-1:0]     wr_addr;
        logic [BEAT_BITS-1:0]  wr_data;
        logic [BEAT_BYTES-1:0] wr_be;
        logic                  done;
        logic [PG_W-1:0]       done_idx;
    } st_t;

    st_t st_d, st_q;

    logic                 acc;
    logic                 last_blk;
    logic                 hdr_clear;
    logic [BEAT_BITS-1:0] hdr_beat;
    logic [PAY_BITS-1:0]  lo_pay;

    assign in_ready = page_free && !st_q.pend;
    assign acc      = in_valid && in_ready;
    assign last_blk = (st_q.blk == BLK_W'(BLK_N - 1));
    assign hdr_clear = st_q.pend;

    shp_hdr_acc u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (acc),
        .clear (hdr_clear),
        .pos   (st_q.blk[5:0]),
        .hdr   (in_block[65:64]),
        .beat  (hdr_beat)
    );

    shp_pair_buf u_pair (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (acc && !st_q.blk[0]),
        .din   (in_block[PAY_BITS-1:0]),
        .dout  (lo_pay)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        st_d.done     = 1'b0;
        if (st_q.pend) begin
            // header beat takes the write port; input is stalled
            st_d.wr_valid = 1'b1;
            st_d.wr_addr  = {st_q.page, OFF_W'({st_q.hbeat, 4'b0000})};
            st_d.wr_data  = hdr_beat;
            st_d.wr_be    = st_q.pend_last ? LAST_BE : '1;
            st_d.pend     = 1'b0;
            if (st_q.pend_last) begin
                st_d.done     = 1'b1;
                st_d.done_idx = st_q.page;
                st_d.page     = (st_q.page == PG_W'(NUM_PAGES - 1)) ? '0
                                                                    : st_q.page + 1'b1;
            end
        end else if (acc) begin
            if (st_q.blk[0]) begin
                st_d.wr_valid = 1'b1;
                st_d.wr_addr  = {st_q.page,
                                 OFF_W'(HDR_B) + OFF_W'({st_q.blk[BLK_W-1:1], 4'b0000})};
                st_d.wr_data  = {in_block[PAY_BITS-1:0], lo_pay};
                st_d.wr_be    = '1;
            end
            if (st_q.blk[5:0] == 6'd63 || last_blk) begin
                st_d.pend      = 1'b1;
                st_d.pend_last = last_blk;
                st_d.hbeat     = st_q.blk >> 6;
            end
            st_d.blk = last_blk ? '0 : st_q.blk + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid      = st_q.wr_valid;
    assign wr_addr       = st_q.wr_addr;
    assign wr_data       = st_q.wr_data;
    assign wr_be         = st_q.wr_be;
    assign page_done     = st_q.done;
    assign page_done_idx = st_q.done_idx;

    // R8: no free page means no acceptance
    a_r8_gate_no_page: assert property (@(posedge clk) disable iff (!rst_n)
        !page_free |-> !in_ready);

    // R4: input held off while a header beat is pending
    a_r4_stall_during_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !in_ready);

    // R4: a pending header beat reaches the bus next cycle in the header region
    a_r4_hdr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> (wr_valid && (wr_addr[OFF_W-1:0] < OFF_W'(HDR_B))));

    // R2: payload beats always carry full byte enables
    a_r2_payload_full_be: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_addr[OFF_W-1:0] >= OFF_W'(HDR_B))) |-> (wr_be == '1));

    // R6: page completion rides on the partial final header write
    a_r6_done_partial_be: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> (wr_valid && wr_be == LAST_BE));

    // R6: the final payload write precedes completion
    a_r6_done_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_done) |-> $past(wr_valid));
endmodule

// File: tb/tb_shp_page_packer.sv
`timescale 1ns/1ps
module tb_shp_page_packer;
    localparam int  N_BLK     = 496;
    localparam int  HDR_BYTES = 128;
    localparam int  HDR_BEATS = 8;
    localparam int  NPAGES    = 16;
    localparam int  RUN_PAGES = 20;
    localparam logic [15:0] LAST_BE = 16'h0FFF;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [65:0]  in_block;
    logic         page_free;
    logic         wr_valid;
    logic [15:0]  wr_addr;
    logic [127:0] wr_data;
    logic [15:0]  wr_be;
    logic         page_done;
    logic [3:0]   page_done_idx;

    int checks = 0;
    int errors = 0;
    int pages_done = 0;
    int wcount = 0;
    bit hdr_due = 0;
    bit finished = 0;

    logic [63:0] exp_pay [0:N_BLK-1];
    logic [1:0]  exp_hdr [0:N_BLK-1];

    always #2.5 clk = ~clk;

    shp_page_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .page_free(page_free), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .page_done(page_done), .page_done_idx(page_done_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] hdr_beat_exp(input int k);
        logic [127:0] v;
        v = '0;
        for (int i = 0; i < 64; i++) begin
            int idx;
            idx = 64 * k + i;
            if (idx < N_BLK) v[32*(i/16) + 2*(i%16) +: 2] = exp_hdr[idx];
        end
        return v;
    endfunction

    // monitor: sampled on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int off;
            off = int'(wr_addr[11:0]);
            if (hdr_due) begin
                // R4: header beat follows the payload write that closed its group
                chk(wr_valid && off < HDR_BYTES, "R4 header beat follows",
                    {126'd0, wr_valid, 1'b0}, 128'd2);
                hdr_due = 0;
            end
            if (wr_valid) begin
                wcount++;
                // R5: page index in the upper address bits
                chk(wr_addr[15:12] == 4'(pages_done % NPAGES), "R5 page field",
                    128'(wr_addr[15:12]), 128'(pages_done % NPAGES));
                if (off >= HDR_BYTES) begin
                    int j;
                    j = (off - HDR_BYTES) / 16;
                    chk(wr_be == 16'hFFFF, "R2 payload byte enables", 128'(wr_be), 128'hFFFF);
                    chk(wr_data == {exp_pay[2*j+1], exp_pay[2*j]}, "R2 payload data",
                        wr_data, {exp_pay[2*j+1], exp_pay[2*j]});
                    if (((2*j+1) % 64) == 63 || (2*j+1) == N_BLK-1) begin
                        chk(in_ready == 1'b0, "R4 stall during header", 128'(in_ready), 128'd0);
                        hdr_due = 1;
                    end
                end else begin
                    int k;
                    logic [15:0] ebe;
                    k   = off / 16;
                    ebe = (k == HDR_BEATS-1) ? LAST_BE : 16'hFFFF;
                    chk(wr_be == ebe, "R3 header byte enables", 128'(wr_be), 128'(ebe));
                    chk(wr_data == hdr_beat_exp(k), "R3 header data", wr_data, hdr_beat_exp(k));
                end
            end
            if (page_done) begin
                chk(page_done_idx == 4'(pages_done % NPAGES), "R7 page index",
                    128'(page_done_idx), 128'(pages_done % NPAGES));
                chk(wr_valid && off == 112 && wr_be == LAST_BE, "R6 final partial header",
                    {wr_valid, 12'(off), wr_be}, {1'b1, 12'd112, LAST_BE});
                chk(wcount == 256, "R5 writes per page", 128'(wcount), 128'd256);
                wcount = 0;
                pages_done++;
            end
        end
    end

    // mode 0: full rate; 1: sparse valid; 2: random page_free; 3: directed long hold
    task automatic run_page(input int mode);
        int got;
        int hold;
        got  = 0;
        hold = 0;
        while (got < N_BLK) begin
            @(negedge clk);
            case (mode)
                0: begin in_valid = 1'b1; page_free = 1'b1; end
                1: begin in_valid = ($urandom % 2) == 0; page_free = 1'b1; end
                2: begin in_valid = ($urandom % 4) != 0; page_free = ($urandom % 6) != 0; end
                default: begin
                    in_valid = 1'b1;
                    if (got >= 200 && hold < 30) begin page_free = 1'b0; hold++; end
                    else page_free = 1'b1;
                end
            endcase
            in_block = {2'($urandom), $urandom, $urandom};
            #1;
            if (!page_free)
                chk(in_ready == 1'b0, "R8 blocked without free page", 128'(in_ready), 128'd0);
            if (in_valid && in_ready) begin
                exp_pay[got] = in_block[63:0];
                exp_hdr[got] = in_block[65:64];
                got++;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        page_free = 1'b1;
        while (!finished && pages_done < RUN_PAGES && pages_done == 0 + pages_done_target)
            @(negedge clk);
    endtask

    int pages_done_target = 0;

    initial begin
        void'($urandom(32'd13579));
        rst_n = 1'b0; in_valid = 1'b0; page_free = 1'b1; in_block = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(wr_valid == 0 && page_done == 0, "R1 outputs idle in reset",
            {wr_valid, page_done}, 128'd0);
        chk(in_ready == 1'b1, "R1 ready follows page_free", 128'(in_ready), 128'd1);
        page_free = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R1 ready follows page_free low", 128'(in_ready), 128'd0);
        page_free = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 0 && page_done == 0, "R1 idle after reset",
            {wr_valid, page_done}, 128'd0);
        for (int p = 0; p < RUN_PAGES; p++) begin
            int mode;
            mode = (p == 0) ? 0 : (p == 3) ? 3 : (p % 2 == 1) ? 1 : 2; // R9 gaps
            pages_done_target = p;
            run_page(mode);
            while (!finished && pages_done <= p) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            chk(pages_done == RUN_PAGES, "R7 pages completed", 128'(pages_done),
                128'(RUN_PAGES));
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule